// File: doc/BRIEF.md
# Buffered Page Program Engine

This block is the device-side command logic of a serial flash for one command: write bytes into one of two page buffers and then commit that buffer to a page of the main array. The host holds chip select low and shifts in a command byte, three address bytes and then any number of data bytes, one bit per cycle in which the bit strobe is high. The command byte picks the buffer. The address gives the target page and the buffer offset at which the first data byte lands. Data bytes fill the buffer at rising offsets and wrap at the end of the page.

When chip select is released after a complete header, a self-timed sequence starts. It first erases the addressed page to all ones and then copies the whole selected buffer into it, one byte per clock. The busy output is high for the whole sequence. Two addressing layouts are supported, chosen by a static mode input: a 1056-byte page and a 1024-byte page. The buffers and a small page array are modelled inside the block, and the array can be read back through a combinational read port.

Top module: `buf_page_prog`

## Requirements
- R1: Command byte 0x82 selects buffer A and 0x85 selects buffer B. After any other command byte, no buffer byte is written and busy stays low when chip select rises.
- R2: In 1056-byte mode (mode input 0), the 24-bit address is sent most significant byte first and each byte most significant bit first. Bits 23..11 form the page number and bits 10..0 the buffer offset. An offset of 1056 or more is reduced by 1056.
- R3: In 1024-byte mode (mode input 1), bits 22..10 form the page number and bits 9..0 the buffer offset. Bit 23 is ignored.
- R4: Each complete data byte is stored in the selected buffer at the current offset, and the offset then advances by one. It wraps to 0 after 1055 in 1056-byte mode and after 1023 in 1024-byte mode.
- R5: When chip select rises after a complete header with a valid command, busy is high from the following clock for exactly ERASE_CLKS + PROG_CLKS clocks.
- R6: When busy falls, page bytes 0 to length-1 equal the selected buffer. Buffer bytes not written in the transaction keep their earlier values and are programmed as they stand.
- R7: If chip select rises before the third address byte is complete, busy stays low and the page array is unchanged.
- R8: A partial data byte (fewer than 8 bits) that is pending when chip select rises is discarded, and the buffer keeps its earlier value at that offset.
- R9: The page number selects array slot (page mod NUM_PAGES).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| binary_mode | input | 1 | 0 = 1056-byte page layout, 1 = 1024-byte page layout |
| cs_n | input | 1 | Active-low chip select; its rising edge starts the commit |
| bit_vld | input | 1 | Qualifies sdi for one bit per clock |
| sdi | input | 1 | Serial data, most significant bit first |
| busy | output | 1 | High while the erase and program sequence runs |
| rd_page | input | PG_W (13) | Page number for array readback (reduced mod NUM_PAGES) |
| rd_off | input | OFF_W (11) | Byte offset for array readback |
| rd_byte | output | 8 | Array byte at rd_page/rd_off (0 for offsets past the page) |

## Verification
The sweeps read every byte of a page after each commit. A design that wraps the offset at 2048 instead of 1056 would scatter the bytes that follow offset 1055, and one that clears untouched buffer bytes would break the retained regions around a short write. Offsets of 1056 and above and binary-mode addresses with bit 23 set are sent so that a design which truncates or misaligns the offset field writes to the wrong place. An aborted header, an unknown command byte and a trailing partial byte are each followed by full-page compares, so that a design which starts a commit too early, or commits a half-shifted byte, leaves a visible mismatch.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
   localparam logic [7:0] CMD_BUF_A = 8'h82;
   localparam logic [7:0] CMD_BUF_B = 8'h85;
   localparam int         HDR_BYTES = 4;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ERASE = 2'd1,
      SQ_PROG  = 2'd2
   } sq_state_e;
endpackage

// File: rtl/bpp_rx.sv
module bpp_rx
   import bpp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       hold,
   input  logic       bit_vld,
   input  logic       sdi,
   output logic       byte_stb,
   output logic [7:0] byte_val,
   output logic [2:0] hdr_cnt
);
   logic [2:0] bit_cnt;
   logic [6:0] shreg;
   logic       take;

   assign take     = bit_vld && !cs_n && !hold;
   assign byte_stb = take && (bit_cnt == 3'd7);
   assign byte_val = {shreg, sdi};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
         hdr_cnt <= '0;
      end else if (cs_n || hold) begin
         bit_cnt <= '0;
         hdr_cnt <= '0;
      end else if (take) begin
         bit_cnt <= bit_cnt + 3'd1;
         shreg   <= {shreg[5:0], sdi};
         if (bit_cnt == 3'd7 && hdr_cnt != 3'(HDR_BYTES))
            hdr_cnt <= hdr_cnt + 3'd1;
      end
   end

   // R8
   frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (bit_cnt == 3'd0 && hdr_cnt == 3'd0));
endmodule

// File: rtl/bpp_seq.sv
module bpp_seq
   import bpp_pkg::*;
#(
   parameter int STD_BYTES  = 1056,
   parameter int ERASE_CLKS = 1100,
   parameter int PROG_CLKS  = 1100,
   parameter int OFF_W      = 11
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OFF_W-1:0] len,
   output logic             busy,
   output logic             erasing,
   output logic             pg_we,
   output logic [OFF_W-1:0] idx
);
   localparam int MAXC  = (ERASE_CLKS > PROG_CLKS) ? ERASE_CLKS : PROG_CLKS;
   localparam int CNT_W = $clog2(MAXC + 1);

   if (ERASE_CLKS < STD_BYTES || PROG_CLKS < STD_BYTES) begin : g_bad_time
      $error("each phase needs at least one clock per page byte");
   end

   sq_state_e        st;
   logic [CNT_W-1:0] cnt;
   logic [OFF_W-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SQ_IDLE;
         cnt   <= '0;
         len_q <= '0;
      end else begin
         case (st)
            SQ_IDLE: if (start) begin
               st    <= SQ_ERASE;
               cnt   <= '0;
               len_q <= len;
            end
            SQ_ERASE: if (cnt == CNT_W'(ERASE_CLKS - 1)) begin
               st  <= SQ_PROG;
               cnt <= '0;
            end else cnt <= cnt + 1'b1;
            SQ_PROG: if (cnt == CNT_W'(PROG_CLKS - 1)) begin
               st  <= SQ_IDLE;
               cnt <= '0;
            end else cnt <= cnt + 1'b1;
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign busy    = (st != SQ_IDLE);
   assign erasing = (st == SQ_ERASE);
   assign pg_we   = busy && (cnt < CNT_W'(len_q));
   assign idx     = cnt[OFF_W-1:0];

   // R5
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && erasing));
   // R5
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(st) == SQ_PROG));
   // R5
   erase_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erasing |-> (cnt < CNT_W'(ERASE_CLKS)));
endmodule

// File: rtl/buf_page_prog.sv
module buf_page_prog
   import bpp_pkg::*;
#(
   parameter int STD_BYTES  = 1056,
   parameter int BIN_BYTES  = 1024,
   parameter int NUM_PAGES  = 2,
   parameter int PG_W       = 13,
   parameter int OFF_W      = 11,
   parameter int ERASE_CLKS = 1100,
   parameter int PROG_CLKS  = 1100
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             binary_mode,
   input  logic             cs_n,
   input  logic             bit_vld,
   input  logic             sdi,
   output logic             busy,
   input  logic [PG_W-1:0]  rd_page,
   input  logic [OFF_W-1:0] rd_off,
   output logic [7:0]       rd_byte
);
   localparam int NUM_BUFS  = 2;
   localparam int ADDR_W    = 24;
   localparam int BIN_OFF_W = $clog2(BIN_BYTES);
   localparam int PIDX_W    = $clog2(NUM_PAGES);

   if (PG_W + OFF_W != ADDR_W || PG_W + BIN_OFF_W > ADDR_W - 1) begin : g_bad_addr
      $error("address fields do not fit the 24-bit address");
   end
   if (STD_BYTES >= 2**OFF_W || 2*STD_BYTES < 2**OFF_W) begin : g_bad_std
      $error("page size must allow a single-step offset reduction");
   end
   if (2**BIN_OFF_W != BIN_BYTES || BIN_BYTES > STD_BYTES) begin : g_bad_bin
      $error("binary page must be a power of two no larger than the buffer");
   end
   if (NUM_PAGES < 2 || 2**PIDX_W != NUM_PAGES || PIDX_W > PG_W) begin : g_bad_pages
      $error("page count must be a power of two of at least 2");
   end

   logic             byte_stb;
   logic [7:0]       byte_val;
   logic [2:0]       hdr_cnt;
   logic             cs_q;
   logic [7:0]       op_q;
   logic [15:0]      addr_q;
   logic             sel_q;
   logic [PG_W-1:0]  pg_q;
   logic [OFF_W-1:0] ptr_q;
   logic             op_ok, in_data, wr_any, start;
   logic [OFF_W-1:0] len_cur, off_raw, off_red;
   logic [PG_W-1:0]  pg_nxt;
   logic [ADDR_W-1:0] full_addr;
   logic             erasing, pg_we;
   logic [OFF_W-1:0] seq_idx;
   logic             tgt_sel;
   logic [PIDX_W-1:0] tgt_slot;
   logic [7:0]       buf_rd [NUM_BUFS];

   bpp_rx u_rx (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold(busy),
      .bit_vld(bit_vld), .sdi(sdi),
      .byte_stb(byte_stb), .byte_val(byte_val), .hdr_cnt(hdr_cnt)
   );

   assign op_ok     = (op_q == CMD_BUF_A) || (op_q == CMD_BUF_B);
   assign in_data   = (hdr_cnt == 3'(HDR_BYTES));
   assign wr_any    = byte_stb && in_data && op_ok;
   assign len_cur   = binary_mode ? OFF_W'(BIN_BYTES) : OFF_W'(STD_BYTES);
   assign full_addr = {addr_q, byte_val};

   always_comb begin
      if (binary_mode) begin
         pg_nxt  = full_addr[BIN_OFF_W+PG_W-1:BIN_OFF_W];
         off_raw = OFF_W'(full_addr[BIN_OFF_W-1:0]);
      end else begin
         pg_nxt  = full_addr[ADDR_W-1:OFF_W];
         off_raw = full_addr[OFF_W-1:0];
      end
   end

   if (STD_BYTES == 2**OFF_W) begin : g_no_reduce
      assign off_red = off_raw;
   end else begin : g_reduce
      assign off_red = (off_raw >= OFF_W'(STD_BYTES)) ? off_raw - OFF_W'(STD_BYTES) : off_raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         op_q   <= '0;
         addr_q <= '0;
         sel_q  <= 1'b0;
         pg_q   <= '0;
         ptr_q  <= '0;
      end else begin
         cs_q <= cs_n;
         if (byte_stb) begin
            case (hdr_cnt)
               3'd0:       op_q   <= byte_val;
               3'd1, 3'd2: addr_q <= {addr_q[7:0], byte_val};
               3'd3: begin
                  pg_q  <= pg_nxt;
                  ptr_q <= off_red;
                  sel_q <= (op_q == CMD_BUF_B);
               end
               default: if (op_ok)
                  ptr_q <= (ptr_q == len_cur - 1'b1) ? '0 : ptr_q + 1'b1;
            endcase
         end
      end
   end

   assign start = cs_n && !cs_q && in_data && op_ok && !busy;

   for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
      logic [7:0] mem [STD_BYTES];
      always_ff @(posedge clk) begin
         if (wr_any && (sel_q == 1'(b)))
            mem[ptr_q] <= byte_val;
      end
      assign buf_rd[b] = mem[seq_idx];
   end

   bpp_seq #(
      .STD_BYTES(STD_BYTES), .ERASE_CLKS(ERASE_CLKS),
      .PROG_CLKS(PROG_CLKS), .OFF_W(OFF_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .len(len_cur),
      .busy(busy), .erasing(erasing), .pg_we(pg_we), .idx(seq_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_sel  <= 1'b0;
         tgt_slot <= '0;
      end else if (start) begin
         tgt_sel  <= sel_q;
         tgt_slot <= pg_q[PIDX_W-1:0];
      end
   end

   logic [7:0] pg_mem [NUM_PAGES][STD_BYTES];
   always_ff @(posedge clk) begin
      if (pg_we)
         pg_mem[tgt_slot][seq_idx] <= erasing ? 8'hFF : buf_rd[tgt_sel];
   end

   assign rd_byte = (rd_off < OFF_W'(STD_BYTES)) ? pg_mem[rd_page[PIDX_W-1:0]][rd_off] : 8'h00;

   // R4
   buf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && ptr_q == len_cur - 1'b1) |=> (ptr_q == '0));
   // R4
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_data |-> (ptr_q < OFF_W'(STD_BYTES)));
   // R7
   rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(cs_n) && !$past(cs_q)));
endmodule

// File: tb/tb_buf_page_prog.sv
`timescale 1ns/1ps
module tb_buf_page_prog;
   localparam int SB = 1056;
   localparam int BB = 1024;
   localparam int EC = 1060;
   localparam int PC = 1070;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        binary_mode = 1'b0;
   logic        cs_n = 1'b1;
   logic        bit_vld = 1'b0;
   logic        sdi = 1'b0;
   logic        busy;
   logic [12:0] rd_page = '0;
   logic [10:0] rd_off = '0;
   logic [7:0]  rd_byte;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   int exp_buf [2][SB];
   int exp_pg  [2][SB];

   always #4 clk = ~clk;

   buf_page_prog #(.ERASE_CLKS(EC), .PROG_CLKS(PC)) dut (
      .clk(clk), .rst_n(rst_n), .binary_mode(binary_mode), .cs_n(cs_n),
      .bit_vld(bit_vld), .sdi(sdi), .busy(busy),
      .rd_page(rd_page), .rd_off(rd_off), .rd_byte(rd_byte)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         @(negedge clk);
         sdi     = b[i];
         bit_vld = 1'b1;
      end
   endtask

   // op: command byte; nadr: address bytes sent; n data bytes = base + 13*i; part: trailing bits
   task automatic run_cmd(input string req, input logic [7:0] op, input logic [23:0] addr,
                          input int nadr, input int n, input int base, input int part);
      int sel, pg, off, len, cnt, slot;
      bit go;
      @(negedge clk);
      cs_n = 1'b0;
      send_bits(op, 8);
      for (int a = 0; a < nadr; a++) send_bits(addr[23-8*a -: 8], 8);
      for (int i = 0; i < n; i++) send_bits(8'(base + 13*i), 8);
      if (part > 0) send_bits(8'hA5, part);
      @(negedge clk);
      bit_vld = 1'b0;
      cs_n    = 1'b1;
      go = (nadr == 3) && (op == 8'h82 || op == 8'h85);
      if (go) begin
         sel = (op == 8'h85) ? 1 : 0;
         if (binary_mode) begin
            pg = (addr >> 10) & 13'h1FFF; off = addr & 10'h3FF; len = BB;
         end else begin
            pg = addr >> 11; off = addr & 11'h7FF; len = SB;
            if (off >= SB) off -= SB;
         end
         for (int i = 0; i < n; i++) begin
            exp_buf[sel][off] = (base + 13*i) & 8'hFF;
            off = (off + 1) % len;
         end
         slot = pg % 2;
         for (int i = 0; i < len; i++) exp_pg[slot][i] = exp_buf[sel][i];
      end
      cnt = 0;
      for (int k = 0; k < EC + PC + 20; k++) begin
         @(negedge clk);
         if (k == 0) check({req, " busy one clock after cs rise"}, int'(busy), int'(go));
         if (busy) cnt++;
      end
      check({req, " busy length"}, cnt, go ? EC + PC : 0);
   endtask

   task automatic check_page(input string req, input int slot, input int len);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rd_page = 13'(slot);
         rd_off  = 11'(i);
         #1;
         check(req, int'(rd_byte), exp_pg[slot][i]);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R5 reset busy low", int'(busy), 0);

      // R1 R2 R4 R5 R6: buffer A full fill to page 0
      run_cmd("R1 R5", 8'h82, 24'h000000, 3, SB, 3, 0);
      check_page("R6 full page A", 0, SB);
      // R1 R6: buffer B full fill to page 1
      run_cmd("R1 R5", 8'h85, {13'd1, 11'd0}, 3, SB, 100, 0);
      check_page("R6 full page B", 1, SB);
      // R4 R9: wrap at 1055, page 3 lands in slot 1, rest of buffer retained
      run_cmd("R4 R9", 8'h85, {13'd3, 11'd1050}, 3, 10, 200, 0);
      check_page("R4 wrap and R9 slot", 1, SB);
      // R2 R8: offset 2000 reduced to 944, trailing 5 bits discarded
      run_cmd("R2 R8", 8'h82, {13'd0, 11'd2000}, 3, 2, 60, 5);
      check_page("R2 reduce and R8 partial", 0, SB);
      // R7: header cut after two address bytes
      run_cmd("R7", 8'h82, {13'd1, 11'd0}, 2, 0, 0, 0);
      check_page("R7 page 0 unchanged", 0, SB);
      check_page("R7 page 1 unchanged", 1, SB);
      // R1: unknown command byte, data must not reach buffer A
      run_cmd("R1 bad op", 8'h83, {13'd0, 11'd5}, 3, 4, 77, 0);
      check_page("R1 page 0 unchanged", 0, SB);
      // R3: binary layout, bit 23 set, page 1, offset 1020, wrap at 1023
      binary_mode = 1'b1;
      run_cmd("R3", 8'h82, 24'h800000 | (24'd1 << 10) | 24'd1020, 3, 6, 50, 0);
      check_page("R3 binary page", 1, BB);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule